// File: doc/BRIEF.md
# Raw Camera Pixel Unpacker

This block sits between a camera receiver's payload output and a memory writer. It takes one byte of line payload per accepted transfer and rebuilds the pixels that the camera sent. Some formats pack several pixels into a few bytes, with the low-order bits of a group of pixels gathered into one trailing byte. The block then packs the pixels into 64-bit words for the memory side. Eight-bit pixels take one byte each in the output. Every deeper pixel takes a 16-bit container, right-justified, with the unused upper bits at zero. No compression stage sits in the path.

A `depth` input picks the layout and is held steady for a whole line. A line-end marker on the last payload byte closes the line. Whole pixels still waiting are flushed in a final word, and its byte-enable mask shows which lanes hold data. Bytes of a group that the line end cuts short are dropped. A line-start marker makes the byte it comes with the first byte of a new group.

Top module: `raw_pixel_unpacker`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `depth` = 0, each input byte is one pixel. Pixel i of a word sits in byte lane i (bits [8i+7:8i]), and eight pixels fill one word.
- R3: With `depth` = 1, every 5 bytes give 4 pixels. Byte k (k = 0..3) is bits [9:2] of pixel k, and bits [2k+1:2k] of byte 4 are bits [1:0] of pixel k. Pixel k goes to bits [16k+9:16k], and bits [16k+15:16k+10] are zero.
- R4: With `depth` = 2, every 3 bytes give 2 pixels. Bytes 0 and 1 are bits [11:4] of pixels 0 and 1. Bits [3:0] of byte 2 are the low nibble of pixel 0, and bits [7:4] are the low nibble of pixel 1. Each pixel is zero-extended in a 16-bit lane.
- R5: With `depth` = 3, byte pairs form 16-bit pixels, the first byte of the pair being the low byte.
- R6: `depth` values 4 to 7 give exactly the output of `depth` = 0.
- R7: Every word not flagged `out_eol` has `out_be` = 8'hFF. The word flagged `out_eol` carries the pixels pending at line end, and `out_be` bit i is set exactly for the lanes filled.
- R8: Bytes of an unfinished group at line end produce no pixel. If no pixel is pending at line end, a word with `out_be` = 0 and `out_eol` = 1 is still emitted.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output word holds steady. Input is then throttled through `in_ready`, and no pixel is lost or repeated.
- R10: A byte with `in_sol` set becomes byte 0 of a fresh group, and bytes of an earlier unfinished group are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| depth | input | 3 | Layout select: 0 8-bit, 1 10-bit, 2 12-bit, 3 16-bit LE, others as 0 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Payload byte |
| in_sol | input | 1 | Byte is the first of a line |
| in_eol | input | 1 | Byte is the last of a line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 64 | Packed pixel word |
| out_be | output | 8 | Byte enables of out_data |
| out_eol | output | 1 | Word closes a line |

## Verification
The in-RTL assertions check on every cycle that the group byte index stays inside the group and that a word never overflows. They also check that any word without a line end is full, that stalled chunks and words stay stable, and that 10-bit and 12-bit containers keep their upper bits at zero. Only the bench can show that bit fields are recombined into the right pixels and lanes, and that unsupported depths match 8-bit output. The bench scenarios also cover dropping of truncated groups, realignment on line start, and loss-free throughput under backpressure.

// File: rtl/raw_unpack_pkg.sv
// Shared layout encoding and group geometry for the raw pixel unpacker.
// Assumes depth is held constant for the duration of a line.
package raw_unpack_pkg;

    typedef enum logic [2:0] {
        DEPTH_8  = 3'd0,
        DEPTH_10 = 3'd1,
        DEPTH_12 = 3'd2,
        DEPTH_16 = 3'd3
    } depth_e;

    // Map the raw select onto a supported layout; anything else acts as 8-bit.
    function automatic depth_e decode_depth(input logic [2:0] sel);
        case (sel)
            3'd1:    return DEPTH_10;
            3'd2:    return DEPTH_12;
            3'd3:    return DEPTH_16;
            default: return DEPTH_8;
        endcase
    endfunction

    // Input bytes per complete group.
    function automatic logic [2:0] group_bytes(input depth_e d);
        case (d)
            DEPTH_10: return 3'd5;
            DEPTH_12: return 3'd3;
            DEPTH_16: return 3'd2;
            default:  return 3'd1;
        endcase
    endfunction

    // Output bytes produced by one complete group.
    function automatic logic [3:0] chunk_bytes(input depth_e d);
        case (d)
            DEPTH_10: return 4'd8;
            DEPTH_12: return 4'd4;
            DEPTH_16: return 4'd2;
            default:  return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/px_gather.sv
// Collects payload bytes into layout groups and turns each completed group
// into a chunk of output bytes (pixels in their output containers).
// Assumes depth only changes between lines. A group cut short by a line end
// yields an empty chunk that still carries the line-end flag.
module px_gather
    import raw_unpack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  depth,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_sol,
    input  logic        in_eol,
    output logic        chk_valid,
    input  logic        chk_ready,
    output logic [63:0] chk_data,
    output logic [3:0]  chk_n,
    output logic        chk_eol
);

    localparam int HELD = 4;

    depth_e      dsel;
    logic [2:0]  grp;
    logic [2:0]  idx;
    logic [2:0]  pos;
    logic        take;
    logic        last;
    logic [7:0]  held [HELD];
    logic [63:0] asm10, asm12, asm16, asm8, asm_sel;

    // Flow control: a byte may enter while the chunk slot is free or draining.
    assign in_ready = !chk_valid || chk_ready;

    // Decode group geometry and locate the incoming byte in its group.
    always_comb begin
        dsel = decode_depth(depth);
        grp  = group_bytes(dsel);
        take = in_valid && in_ready;
        pos  = in_sol ? 3'd0 : idx;
        last = (pos == grp - 3'd1);
    end

    // 10-bit: four pixels, low bit pairs taken from the trailing byte.
    genvar k;
    generate
        for (k = 0; k < 4; k++) begin : g_p10
            assign asm10[16*k +: 16] = {6'b0, held[k], in_data[2*k +: 2]};
        end
    endgenerate

    assign asm12 = {32'b0, 4'b0, held[1], in_data[7:4], 4'b0, held[0], in_data[3:0]};
    assign asm16 = {48'b0, in_data, held[0]};
    assign asm8  = {56'b0, in_data};

    // Select the assembled chunk for the active layout.
    always_comb begin
        case (dsel)
            DEPTH_10: asm_sel = asm10;
            DEPTH_12: asm_sel = asm12;
            DEPTH_16: asm_sel = asm16;
            default:  asm_sel = asm8;
        endcase
    end

    // Store group bytes and publish a chunk on group completion or line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            chk_valid <= 1'b0;
            chk_data  <= '0;
            chk_n     <= '0;
            chk_eol   <= 1'b0;
            for (int i = 0; i < HELD; i++) held[i] <= '0;
        end else begin
            if (chk_valid && chk_ready) chk_valid <= 1'b0;
            if (take) begin
                if (last) begin
                    chk_valid <= 1'b1;
                    chk_data  <= asm_sel;
                    chk_n     <= chunk_bytes(dsel);
                    chk_eol   <= in_eol;
                    idx       <= '0;
                end else if (in_eol) begin
                    chk_valid <= 1'b1;
                    chk_data  <= '0;
                    chk_n     <= '0;
                    chk_eol   <= 1'b1;
                    idx       <= '0;
                end else begin
                    held[pos[1:0]] <= in_data;
                    idx            <= pos + 3'd1;
                end
            end
        end
    end

    assert_idx_in_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idx < grp);

    assert_chunk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && !chk_ready |=> chk_valid && $stable(chk_data) && $stable(chk_n));

endmodule

// File: rtl/px_pack.sv
// Appends chunks of output bytes into a word and emits the word when full or
// at line end, with a byte-enable mask for the lanes filled.
// Assumes chunk sizes divide OUT_BYTES and depth is constant within a line,
// so a chunk never straddles two words.
module px_pack #(
    parameter int OUT_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   chk_valid,
    output logic                   chk_ready,
    input  logic [63:0]            chk_data,
    input  logic [3:0]             chk_n,
    input  logic                   chk_eol,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [OUT_BYTES*8-1:0] out_data,
    output logic [OUT_BYTES-1:0]   out_be,
    output logic                   out_eol
);

    localparam int OUT_W  = OUT_BYTES * 8;
    localparam int FILL_W = $clog2(OUT_BYTES + 1) + 1;

    logic [OUT_W-1:0]     acc;
    logic [FILL_W-1:0]    fill;
    logic [FILL_W-1:0]    new_fill;
    logic [OUT_W-1:0]     merged;
    logic [OUT_BYTES-1:0] nmask;
    logic                 load;

    // Accept a chunk while the output register is free or draining.
    assign chk_ready = !out_valid || out_ready;
    assign load      = chk_valid && chk_ready;

    // Place the chunk above the bytes already collected.
    always_comb begin
        new_fill = fill + FILL_W'(chk_n);
        merged   = acc | (OUT_W'(chk_data) << {fill, 3'b000});
    end

    genvar i;
    generate
        for (i = 0; i < OUT_BYTES; i++) begin : g_mask
            assign nmask[i] = (FILL_W'(i) < new_fill);
        end
    endgenerate

    // Accumulate chunks; hand a word to the output register when due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            fill      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_be    <= '0;
            out_eol   <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (load) begin
                if (new_fill == FILL_W'(OUT_BYTES) || chk_eol) begin
                    out_valid <= 1'b1;
                    out_data  <= merged;
                    out_be    <= nmask;
                    out_eol   <= chk_eol;
                    acc       <= '0;
                    fill      <= '0;
                end else begin
                    acc  <= merged;
                    fill <= new_fill;
                end
            end
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (fill + FILL_W'(chk_n)) <= FILL_W'(OUT_BYTES));

    assert_full_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_eol |-> &out_be);

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be)
                                    && $stable(out_eol));

endmodule

// File: rtl/raw_pixel_unpacker.sv
// Top of the raw pixel unpacker: byte stream in, packed pixel words out.
// Assumes depth is static across a line and OUT_BYTES is a multiple of 8.
module raw_pixel_unpacker
    import raw_unpack_pkg::*;
#(
    parameter int OUT_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             depth,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [7:0]             in_data,
    input  logic                   in_sol,
    input  logic                   in_eol,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [OUT_BYTES*8-1:0] out_data,
    output logic [OUT_BYTES-1:0]   out_be,
    output logic                   out_eol
);

    localparam int OUT_W = OUT_BYTES * 8;

    logic        chk_valid, chk_ready, chk_eol;
    logic [63:0] chk_data;
    logic [3:0]  chk_n;

    px_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .depth     (depth),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_sol    (in_sol),
        .in_eol    (in_eol),
        .chk_valid (chk_valid),
        .chk_ready (chk_ready),
        .chk_data  (chk_data),
        .chk_n     (chk_n),
        .chk_eol   (chk_eol)
    );

    px_pack #(.OUT_BYTES(OUT_BYTES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_valid (chk_valid),
        .chk_ready (chk_ready),
        .chk_data  (chk_data),
        .chk_n     (chk_n),
        .chk_eol   (chk_eol),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_be    (out_be),
        .out_eol   (out_eol)
    );

    localparam logic [OUT_W-1:0] HI10 = {(OUT_BYTES/2){16'hFC00}};
    localparam logic [OUT_W-1:0] HI12 = {(OUT_BYTES/2){16'hF000}};

    assert_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && decode_depth(depth) == DEPTH_10 |-> (out_data & HI10) == '0);

    assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && decode_depth(depth) == DEPTH_12 |-> (out_data & HI12) == '0);

endmodule

// File: tb/raw_pixel_unpacker_tb.sv
`timescale 1ns/1ps
module raw_pixel_unpacker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  depth = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_sol = 1'b0;
    logic        in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;
    logic [7:0]  out_be;
    logic        out_eol;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    raw_pixel_unpacker dut_i (
        .clk(clk), .rst_n(rst_n), .depth(depth),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sol(in_sol), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_be(out_be), .out_eol(out_eol)
    );

    // Vector: depth(3) count(4) bytes(80, byte0 lowest) exp_data(64) exp_be(8)
    localparam int NV = 10;
    localparam logic [158:0] VECS [NV] = '{
        {3'd0, 4'd8, 80'h0000_0807060504030201, 64'h0807060504030201, 8'hFF},
        {3'd0, 4'd3, 80'h0000_0000000000CCBBAA, 64'h0000000000CCBBAA, 8'h07},
        {3'd1, 4'd5, 80'h0000_000000E4018000FF, 64'h0007_0202_0001_03FC, 8'hFF},
        {3'd2, 4'd3, 80'h0000_00000000005ECDAB, 64'h0000_0000_0CD5_0ABE, 8'h0F},
        {3'd3, 4'd4, 80'h0000_0000000056781234, 64'h0000_0000_5678_1234, 8'h0F},
        {3'd5, 4'd2, 80'h0000_0000000000002211, 64'h0000_0000_0000_2211, 8'h03},
        {3'd2, 4'd5, 80'h0000_0000008877F03412, 64'h0000_0000_034F_0120, 8'h0F},
        {3'd1, 4'd3, 80'h0000_0000000000030201, 64'h0000_0000_0000_0000, 8'h00},
        {3'd3, 4'd3, 80'h0000_0000000000991234, 64'h0000_0000_0000_1234, 8'h03},
        {3'd7, 4'd8, 80'h0000_8877665544332211, 64'h8877665544332211, 8'hFF}
    };

    function automatic string vtag(input int i);
        case (i)
            0: return "R2";
            1: return "R7";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R8";
            7: return "R8";
            8: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Captured output words
    logic [63:0] got_d [$];
    logic [7:0]  got_be [$];
    logic        got_eol [$];
    logic        stall_seen = 1'b0;
    logic [63:0] stall_d = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: sample away from the edge, record words that will be accepted.
    always begin
        @(negedge clk);
        #2;
        if (rst_n && out_valid) begin
            if (stall_seen)
                check(out_data == stall_d, "R9 hold", out_data, stall_d);
            if (out_ready) begin
                got_d.push_back(out_data);
                got_be.push_back(out_be);
                got_eol.push_back(out_eol);
                stall_seen = 1'b0;
            end else begin
                stall_seen = 1'b1;
                stall_d    = out_data;
            end
        end else begin
            stall_seen = 1'b0;
        end
    end

    task automatic send(input logic [7:0] b, input logic sol, input logic eol);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_sol = sol; in_eol = eol;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
        #3;
    endtask

    task automatic flush_q();
        got_d.delete(); got_be.delete(); got_eol.delete();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);

        // Table walk: one line per vector, one word expected each
        for (int v = 0; v < NV; v++) begin
            logic [2:0]  vd;
            logic [3:0]  vn;
            logic [79:0] vb;
            logic [63:0] ed;
            logic [7:0]  eb;
            {vd, vn, vb, ed, eb} = VECS[v];
            flush_q();
            depth = vd;
            for (int j = 0; j < int'(vn); j++)
                send(vb[8*j +: 8], j == 0, j == int'(vn) - 1);
            settle();
            check(got_d.size() == 1, vtag(v), 64'(got_d.size()), 64'd1);
            if (got_d.size() == 1) begin
                check(got_d[0] == ed, vtag(v), got_d[0], ed);
                check(got_be[0] == eb, vtag(v), 64'(got_be[0]), 64'(eb));
                check(got_eol[0] == 1'b1, vtag(v), 64'(got_eol[0]), 64'd1);
            end
        end

        // R7/R3: two 10-bit groups -> full non-final word, then final word
        flush_q();
        depth = 3'd1;
        send(8'hFF, 1'b1, 1'b0); send(8'h00, 1'b0, 1'b0); send(8'h80, 1'b0, 1'b0);
        send(8'h01, 1'b0, 1'b0); send(8'hE4, 1'b0, 1'b0);
        send(8'h10, 1'b0, 1'b0); send(8'h20, 1'b0, 1'b0); send(8'h30, 1'b0, 1'b0);
        send(8'h40, 1'b0, 1'b0); send(8'h00, 1'b0, 1'b1);
        settle();
        check(got_d.size() == 2, "R7 count", 64'(got_d.size()), 64'd2);
        if (got_d.size() == 2) begin
            check(got_eol[0] == 1'b0 && got_be[0] == 8'hFF, "R7 first",
                  {got_eol[0], got_be[0]}, 64'h0FF);
            check(got_d[1] == 64'h0100_00C0_0080_0040, "R3 second", got_d[1],
                  64'h0100_00C0_0080_0040);
            check(got_eol[1] == 1'b1, "R7 last eol", 64'(got_eol[1]), 64'd1);
        end

        // R10: line start realigns the group, dropping the stray bytes
        flush_q();
        depth = 3'd1;
        send(8'hAA, 1'b1, 1'b0); send(8'hBB, 1'b0, 1'b0);
        send(8'hFF, 1'b1, 1'b0); send(8'h00, 1'b0, 1'b0); send(8'h80, 1'b0, 1'b0);
        send(8'h01, 1'b0, 1'b0); send(8'hE4, 1'b0, 1'b1);
        settle();
        check(got_d.size() == 1, "R10 count", 64'(got_d.size()), 64'd1);
        if (got_d.size() == 1)
            check(got_d[0] == 64'h0007_0202_0001_03FC, "R10 data", got_d[0],
                  64'h0007_0202_0001_03FC);

        // R9: backpressure, 16 bytes of 8-bit pixels with output stalled
        flush_q();
        depth = 3'd0;
        @(negedge clk);
        out_ready = 1'b0;
        fork
            begin
                for (int j = 0; j < 16; j++)
                    send(8'(j + 1), j == 0, j == 15);
            end
            begin
                repeat (40) @(negedge clk);
                #1;
                check(in_ready == 1'b0, "R9 throttle", 64'(in_ready), 64'd0);
                check(out_valid == 1'b1, "R9 valid held", 64'(out_valid), 64'd1);
                @(negedge clk);
                out_ready = 1'b1;
            end
        join
        settle();
        check(got_d.size() == 2, "R9 count", 64'(got_d.size()), 64'd2);
        if (got_d.size() == 2) begin
            check(got_d[0] == 64'h0807060504030201, "R9 word0", got_d[0],
                  64'h0807060504030201);
            check(got_d[1] == 64'h100F0E0D0C0B0A09, "R9 word1", got_d[1],
                  64'h100F0E0D0C0B0A09);
            check(got_eol[1] == 1'b1, "R9 eol", 64'(got_eol[1]), 64'd1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule